// File: doc/BRIEF.md
# Machine Timer and Software Interrupt Unit

This block gives one hart its machine-level timer interrupt and software interrupt. It holds a 64-bit time counter, a 64-bit compare value, a software-pending bit and a 64-bit cycle counter whose counting can be suppressed. The core reaches the registers through a small request/response port: it presents an offset, an access width of 4 or 8 bytes, a read/write flag and write data. Exactly one cycle later the port returns a response strobe, an error flag and zero-extended read data.

The time counter advances by one on each `tick` pulse. It cannot be written over the port. The timer interrupt line reports an unsigned comparison of compare against time. The line is refreshed only when a tick occurs or a store is accepted. A wait-for-interrupt hint lets the core skip idle time: when time is still below compare, time and the cycle counter jump straight to the compare value.

Top module: `hart_timer_irq`

## Requirements
- R1: The software-pending word sits at offset 0x0000 and accepts reads and writes of either width. A write loads only data bit 0 into the pending bit, which drives `softIrq`. A read returns the bit in data bit 0 with all other bits zero.
- R2: The compare value accepts an 8-byte read or write at 0x4000. It also accepts 4-byte access to its low half at 0x4000 and to its high half at 0x4004. A 4-byte write changes only the addressed half. An 8-byte access at 0x4004 is an error and has no effect.
- R3: Time can be read as 8 bytes at 0xBFF8, or as 4-byte halves at 0xBFF8 (bits 31:0) and 0xBFFC (bits 63:32). Every write to 0xBFF8 or 0xBFFC, of either width, returns an error and leaves time unchanged.
- R4: A request at any other offset, or with a width the offset does not accept, returns `rspErr`=1 and read data zero, and changes no state.
- R5: In the cycle after a tick or an accepted store, `timerIrq` equals (compare <= time), compared as unsigned 64-bit values and using the updated values. In all other cycles `timerIrq` holds its value.
- R6: Each `tick` adds one to time. It also adds one to `cycleCount`, unless `cycleInhibit` is 1.
- R7: When `wfiHint` is 1 and time is below compare, time and `cycleCount` both take the compare value, and a tick in the same cycle is ignored. When time is not below compare, `wfiHint` has no effect.
- R8: Every request cycle (`reqValid`=1) is answered in the next cycle by a single-cycle `rspValid` along with `rspErr`. A 4-byte read returns its 32-bit value in bits 31:0 with bits 63:32 zero. Write responses carry zero data. `reqWide`=1 selects 8 bytes and 0 selects 4 bytes.
- R9: After reset, time, compare, the cycle counter, the software bit, `timerIrq` and `rspValid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqWide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reqAddr | input | 16 | Register offset |
| reqWdata | input | 64 | Store data (4-byte stores use bits 31:0) |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspErr | output | 1 | Request rejected |
| rspRdata | output | 64 | Zero-extended load data |
| tick | input | 1 | Timebase pulse |
| cycleInhibit | input | 1 | Suppresses cycle counting on ticks |
| wfiHint | input | 1 | Wait-for-interrupt skip request |
| timerIrq | output | 1 | Machine timer interrupt pending |
| softIrq | output | 1 | Machine software interrupt pending |
| cycleCount | output | 64 | Cycle counter value |

## Verification
The hardest state to reach from the ports is a time value that sits beyond 32 bits, or directly next to a compare value with its top bit set. Plain ticking would take billions of cycles to get there. The stimulus first uses 4-byte and 8-byte stores to place compare at such a value, then fires the wait-for-interrupt hint so time jumps there in one cycle. A few ticks then carry time across the 32-bit half boundary and past the unsigned comparison point. Random traffic mixes all offsets and widths with ticks and the hint, so stores that are accepted and refused both interleave with pending-line refreshes.

// File: rtl/htim_pkg.sv
package htim_pkg;
  localparam int CNT_W  = 64;
  localparam int HALF_W = CNT_W / 2;

  localparam logic [15:0] OFS_SOFT    = 16'h0000;
  localparam logic [15:0] OFS_CMP_LO  = 16'h4000;
  localparam logic [15:0] OFS_CMP_HI  = 16'h4004;
  localparam logic [15:0] OFS_TIME_LO = 16'hBFF8;
  localparam logic [15:0] OFS_TIME_HI = 16'hBFFC;

  typedef enum logic [2:0] {
    RD_NONE, RD_SOFT, RD_CMP64, RD_CMP_LO, RD_CMP_HI, RD_TIME64, RD_TIME_LO, RD_TIME_HI
  } rdSel_t;

  typedef struct packed {
    logic   wrSoft;
    logic   wrCmpFull;
    logic   wrCmpLo;
    logic   wrCmpHi;
    rdSel_t rdSel;
  } strobe_t;
endpackage

// File: rtl/htim_ctrl.sv
module htim_ctrl
  import htim_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  output strobe_t           strobe,
  output logic              anyStore,
  output logic              rspValid,
  output logic              rspErr
);
  logic atSoft, atCmpLo, atCmpHi, atTimeLo, atTimeHi, reqOk;

  assign atSoft   = (reqAddr == ADDR_W'(OFS_SOFT));
  assign atCmpLo  = (reqAddr == ADDR_W'(OFS_CMP_LO));
  assign atCmpHi  = (reqAddr == ADDR_W'(OFS_CMP_HI));
  assign atTimeLo = (reqAddr == ADDR_W'(OFS_TIME_LO));
  assign atTimeHi = (reqAddr == ADDR_W'(OFS_TIME_HI));

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    reqOk = 1'b0;
    if (reqValid) begin
      if (reqWrite) begin
        if (atSoft) begin
          strobe.wrSoft = 1'b1;
          reqOk = 1'b1;
        end else if (atCmpLo) begin
          if (reqWide) strobe.wrCmpFull = 1'b1;
          else         strobe.wrCmpLo   = 1'b1;
          reqOk = 1'b1;
        end else if (atCmpHi && !reqWide) begin
          strobe.wrCmpHi = 1'b1;
          reqOk = 1'b1;
        end
      end else begin
        reqOk = 1'b1;
        if (atSoft)                   strobe.rdSel = RD_SOFT;
        else if (atCmpLo)             strobe.rdSel = reqWide ? RD_CMP64 : RD_CMP_LO;
        else if (atCmpHi && !reqWide) strobe.rdSel = RD_CMP_HI;
        else if (atTimeLo)            strobe.rdSel = reqWide ? RD_TIME64 : RD_TIME_LO;
        else if (atTimeHi && !reqWide) strobe.rdSel = RD_TIME_HI;
        else                          reqOk = 1'b0;
      end
    end
  end

  assign anyStore = strobe.wrSoft | strobe.wrCmpFull | strobe.wrCmpLo | strobe.wrCmpHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= reqValid & ~reqOk;
    end
  end

  // R3: stores to the time words are always refused
  assert_time_ro_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && (atTimeLo || atTimeHi)) |=> (rspValid && rspErr));
  // R8: one response per request, one cycle later
  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_rsp_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R4: an accepted store never also reports an error
  assert_store_ok_R4: assert property (@(posedge clk) disable iff (!rstN)
    anyStore |=> !rspErr);
endmodule

// File: rtl/htim_dpath.sv
module htim_dpath
  import htim_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strobe,
  input  logic         anyStore,
  input  logic [W-1:0] wdata,
  input  logic         tick,
  input  logic         wfiHint,
  input  logic         cycleInhibit,
  output logic [W-1:0] rdata,
  output logic         timerIrq,
  output logic         softIrq,
  output logic [W-1:0] cycleCount
);
  localparam int H = W / 2;

  logic [W-1:0] timeQ, cmpQ, cycQ, rdataQ;
  logic [W-1:0] timeNext, cmpNext, cycNext, rdNext;
  logic softQ, irqQ, wfiJump;

  assign wfiJump = wfiHint && (timeQ < cmpQ);

  always_comb begin
    cmpNext = cmpQ;
    if (strobe.wrCmpFull)    cmpNext = wdata;
    else if (strobe.wrCmpLo) cmpNext = {cmpQ[W-1:H], wdata[H-1:0]};
    else if (strobe.wrCmpHi) cmpNext = {wdata[H-1:0], cmpQ[H-1:0]};
  end

  always_comb begin
    if (wfiJump)   timeNext = cmpQ;
    else if (tick) timeNext = timeQ + W'(1);
    else           timeNext = timeQ;
    if (wfiJump)                    cycNext = cmpQ;
    else if (tick && !cycleInhibit) cycNext = cycQ + W'(1);
    else                            cycNext = cycQ;
  end

  always_comb begin
    case (strobe.rdSel)
      RD_SOFT:    rdNext = {{(W-1){1'b0}}, softQ};
      RD_CMP64:   rdNext = cmpQ;
      RD_CMP_LO:  rdNext = {{H{1'b0}}, cmpQ[H-1:0]};
      RD_CMP_HI:  rdNext = {{H{1'b0}}, cmpQ[W-1:H]};
      RD_TIME64:  rdNext = timeQ;
      RD_TIME_LO: rdNext = {{H{1'b0}}, timeQ[H-1:0]};
      RD_TIME_HI: rdNext = {{H{1'b0}}, timeQ[W-1:H]};
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeQ  <= '0;
      cmpQ   <= '0;
      cycQ   <= '0;
      softQ  <= 1'b0;
      irqQ   <= 1'b0;
      rdataQ <= '0;
    end else begin
      timeQ  <= timeNext;
      cmpQ   <= cmpNext;
      cycQ   <= cycNext;
      rdataQ <= rdNext;
      if (strobe.wrSoft) softQ <= wdata[0];
      if (tick || anyStore) irqQ <= (cmpNext <= timeNext);
    end
  end

  assign rdata      = rdataQ;
  assign timerIrq   = irqQ;
  assign softIrq    = softQ;
  assign cycleCount = cycQ;

  // R5: refreshed line matches the unsigned comparison
  assert_irq_refresh_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tick || anyStore) |=> (timerIrq == (cmpQ <= timeQ)));
  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(tick || anyStore) |=> $stable(timerIrq));
  // R6: time step and inhibited cycle count
  assert_time_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !wfiHint) |=> (timeQ == $past(timeQ) + W'(1)));
  assert_cyc_inhibit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cycleInhibit && !wfiHint) |=> $stable(cycQ));
  // R7: skip lands time on the old compare value
  assert_wfi_jump_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wfiHint && (timeQ < cmpQ)) |=> (timeQ == $past(cmpQ) && cycQ == $past(cmpQ)));
endmodule

// File: rtl/hart_timer_irq.sv
module hart_timer_irq
  import htim_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [CNT_W-1:0]  rspRdata,
  input  logic              tick,
  input  logic              cycleInhibit,
  input  logic              wfiHint,
  output logic              timerIrq,
  output logic              softIrq,
  output logic [CNT_W-1:0]  cycleCount
);
  strobe_t strobe;
  logic anyStore;

  htim_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWide(reqWide), .reqAddr(reqAddr), .strobe(strobe), .anyStore(anyStore),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  htim_dpath #(.W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .anyStore(anyStore),
    .wdata(reqWdata), .tick(tick), .wfiHint(wfiHint), .cycleInhibit(cycleInhibit),
    .rdata(rspRdata), .timerIrq(timerIrq), .softIrq(softIrq), .cycleCount(cycleCount)
  );
endmodule

// File: tb/sim_hart_timer_irq.sv
module sim_hart_timer_irq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, reqWide = 0, tick = 0, cycleInhibit = 0, wfiHint = 0;
  logic [15:0] reqAddr = '0;
  logic [63:0] reqWdata = '0;
  logic rspValid, rspErr, timerIrq, softIrq;
  logic [63:0] rspRdata, cycleCount;

  int errors = 0, checks = 0, cyclesRun = 0;
  bit done = 0;

  logic [63:0] mTime = 0, mCmp = 0, mCyc = 0;
  logic mSoft = 0, mIrq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hart_timer_irq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqWide(reqWide),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid), .rspErr(rspErr),
    .rspRdata(rspRdata), .tick(tick), .cycleInhibit(cycleInhibit), .wfiHint(wfiHint),
    .timerIrq(timerIrq), .softIrq(softIrq), .cycleCount(cycleCount)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit accepts(bit w, bit wide, logic [15:0] a);
    if (w) return (a == 16'h0000) || (a == 16'h4000) || (a == 16'h4004 && !wide);
    return (a == 16'h0000) || (a == 16'h4000) || (a == 16'hBFF8) ||
           (a == 16'h4004 && !wide) || (a == 16'hBFFC && !wide);
  endfunction

  function automatic logic [63:0] readVal(bit wide, logic [15:0] a);
    case (a)
      16'h0000: return {63'b0, mSoft};
      16'h4000: return wide ? mCmp : {32'b0, mCmp[31:0]};
      16'h4004: return {32'b0, mCmp[63:32]};
      16'hBFF8: return wide ? mTime : {32'b0, mTime[31:0]};
      16'hBFFC: return {32'b0, mTime[63:32]};
      default:  return 64'h0;
    endcase
  endfunction

  // one clock: drive after a falling edge, check at the next falling edge
  task automatic cyc(string tag, bit v, bit w, bit wide, logic [15:0] a, logic [63:0] d,
                     bit tk, bit wfi, bit inh);
    bit ok, jump, store;
    logic [63:0] expData;
    reqValid = v; reqWrite = w; reqWide = wide; reqAddr = a; reqWdata = d;
    tick = tk; wfiHint = wfi; cycleInhibit = inh;
    ok = accepts(w, wide, a);
    store = v && w && ok;
    expData = (v && !w && ok) ? readVal(wide, a) : 64'h0;
    jump = wfi && (mTime < mCmp);
    if (store && a == 16'h0000) mSoft = d[0];
    if (jump) begin
      mTime = mCmp; mCyc = mCmp;
    end else if (tk) begin
      mTime = mTime + 1;
      if (!inh) mCyc = mCyc + 1;
    end
    if (store && a == 16'h4000) mCmp = wide ? d : {mCmp[63:32], d[31:0]};
    if (store && a == 16'h4004) mCmp = {d[31:0], mCmp[31:0]};
    if (tk || store) mIrq = (mCmp <= mTime);
    @(negedge clk);
    cyclesRun++;
    check(tag, "rspValid", 64'(rspValid), 64'(v));
    if (v) begin
      check(tag, "rspErr", 64'(rspErr), 64'(!ok));
      check(tag, "rspRdata", rspRdata, expData);
    end
    check(tag, "timerIrq", 64'(timerIrq), 64'(mIrq));
    check(tag, "softIrq", 64'(softIrq), 64'(mSoft));
    check(tag, "cycleCount", cycleCount, mCyc);
  endtask

  task automatic idle(string tag, bit tk);
    cyc(tag, 0, 0, 0, 16'h0, 64'h0, tk, 0, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<200000", cyclesRun);
    finishRun();
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "timerIrq", 64'(timerIrq), 0);
    check("R9", "softIrq", 64'(softIrq), 0);
    check("R9", "cycleCount", cycleCount, 0);
    check("R9", "rspValid", 64'(rspValid), 0);
    rstN = 1'b1;
    cyc("R9", 1, 0, 1, 16'hBFF8, 0, 0, 0, 0);
    cyc("R9", 1, 0, 1, 16'h4000, 0, 0, 0, 0);

    // R1: only bit 0 lands in the pending bit, both widths
    cyc("R1", 1, 1, 0, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 0);
    cyc("R1", 1, 1, 1, 16'h0000, 64'h8000_0000_0000_0003, 0, 0, 0);
    cyc("R1", 1, 0, 1, 16'h0000, 0, 0, 0, 0);
    cyc("R1", 1, 0, 0, 16'h0000, 0, 0, 0, 0);

    // R2: halves and full compare, refused wide access at high half
    cyc("R2", 1, 1, 0, 16'h4000, 64'hDEAD_BEEF_0000_0005, 0, 0, 0);
    cyc("R2", 1, 1, 0, 16'h4004, 64'h1234_5678_0000_0001, 0, 0, 0);
    cyc("R2", 1, 1, 1, 16'h4004, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0);
    cyc("R2", 1, 0, 1, 16'h4004, 0, 0, 0, 0);
    cyc("R2", 1, 0, 0, 16'h4004, 0, 0, 0, 0);
    cyc("R2", 1, 0, 1, 16'h4000, 0, 0, 0, 0);

    // R5: top-bit compare must be treated as unsigned (not pending)
    cyc("R5", 1, 1, 1, 16'h4000, 64'h8000_0000_0000_0000, 0, 0, 0);
    idle("R5", 1);
    // R5: compare equal to time pends after a store
    cyc("R5", 1, 1, 1, 16'h4000, mTime, 0, 0, 0);
    cyc("R5", 1, 1, 1, 16'h4000, mTime + 2, 0, 0, 0);
    idle("R5", 1);
    idle("R5", 1);

    // R7: skip to compare, beats a same-cycle tick; no effect when reached
    cyc("R7", 1, 1, 1, 16'h4000, 64'h0000_0000_FFFF_FFFF, 0, 0, 0);
    cyc("R7", 0, 0, 0, 16'h0, 0, 1, 1, 0);
    cyc("R7", 1, 0, 1, 16'hBFF8, 0, 0, 0, 0);
    cyc("R7", 0, 0, 0, 16'h0, 0, 1, 1, 0);

    // R3: time halves across the 32-bit boundary; stores refused
    cyc("R3", 1, 0, 0, 16'hBFFC, 0, 0, 0, 0);
    cyc("R3", 1, 0, 0, 16'hBFF8, 0, 0, 0, 0);
    cyc("R3", 1, 1, 1, 16'hBFF8, 64'h0, 1, 0, 0);
    cyc("R3", 1, 1, 0, 16'hBFFC, 64'h0, 0, 0, 0);
    cyc("R3", 1, 0, 1, 16'hBFF8, 0, 0, 0, 0);
    cyc("R3", 1, 0, 1, 16'hBFFC, 0, 0, 0, 0);

    // R6: inhibited cycle count
    cyc("R6", 0, 0, 0, 16'h0, 0, 1, 0, 1);
    cyc("R6", 0, 0, 0, 16'h0, 0, 1, 0, 0);

    // R4: unlisted offsets
    cyc("R4", 1, 0, 1, 16'h0008, 0, 0, 0, 0);
    cyc("R4", 1, 1, 0, 16'h1234, 64'hFFFF, 0, 0, 0);
    cyc("R4", 1, 0, 0, 16'h4000, 0, 0, 0, 0);

    // R8 and R5: random traffic
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] a;
      logic [63:0] d;
      case ($urandom_range(0, 6))
        0: a = 16'h0000;
        1: a = 16'h4000;
        2: a = 16'h4004;
        3: a = 16'hBFF8;
        4: a = 16'hBFFC;
        5: a = 16'h0008;
        default: a = 16'($urandom);
      endcase
      if ($urandom_range(0, 3) != 0) d = mTime + 64'($urandom_range(0, 12));
      else d = {32'($urandom), 32'($urandom)};
      cyc("R8", $urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
          a, d, $urandom_range(0, 1) == 1, $urandom_range(0, 15) == 0, $urandom_range(0, 3) == 0);
    end
    finishRun();
  end
endmodule